// File: doc/BRIEF.md
# Multi-channel serial frame forwarder

This block merges several asynchronous serial receive lines onto one serial transmit line. Every receive line has its own glitch filter, an 8N1 receiver and an eight-byte FIFO. A scheduler watches the FIFO fill levels. When a channel holds four or more bytes, the scheduler claims that channel for one four-byte frame. The transmitter then takes the frame's bytes one at a time, straight out of that channel's FIFO. The transmitter has no buffer of its own.

All channels keep receiving while a frame is being sent. To keep up with back-to-back traffic on every input, the transmit bit rate should be at least four times the receive bit rate. When several channels become ready in the same cycle, the lowest channel index wins. Bit periods are set by two divisor inputs, one for receive and one for transmit. Each divisor equals the clock frequency divided by the baud rate, for example 50 MHz / 115200.

Top module: `serial_merge`

## Requirements
- R1: While `rst_n` is low and after it is released, `tx_line` is high, `drop_seen` is all zero and every FIFO is empty, so nothing is sent until four new bytes arrive on some channel.
- R2: Every byte on `tx_line` has the 8N1 format. It starts with a low start bit, then sends eight data bits with the most significant bit first, then a high stop bit. Each bit lasts `tx_div` clock cycles.
- R3: Once channel c holds at least four bytes, those four bytes appear on `tx_line` in arrival order. A channel holding three or fewer bytes produces no output.
- R4: A frame of four bytes from one channel is sent complete before any byte of another channel is sent.
- R5: When several channels become ready in the same cycle, their frames go out in ascending channel order, channel 0 first.
- R6: A channel keeps accepting bytes while a frame is being sent. Two frames sent back to back on one channel both come out, with all eight bytes in order.
- R7: A received byte whose stop bit samples low is discarded and never forwarded.
- R8: A falling edge followed by a line that is high again at the half-bit check of the start bit returns the receiver to idle. No byte is produced.
- R9: A low pulse on a receive line shorter than the filter length (4 clocks by default) is ignored. The filtered line changes only when the last samples all agree.
- R10: A byte that arrives while its channel's FIFO holds eight bytes is dropped, and bit c of `drop_seen` goes high. That bit stays high until reset.
- R11: Each receive bit is sampled near its middle, with `rx_div` clock cycles per bit (start bit: `rx_div`/2 cycles after the filtered falling edge). The received bit `rx_line[c]` belongs to channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | N_CH | Serial receive lines; bit c is channel c |
| rx_div | input | DIV_W | Clock cycles per receive bit (at least 4) |
| tx_div | input | DIV_W | Clock cycles per transmit bit (at least 2) |
| tx_line | output | 1 | Merged serial transmit line, idle high |
| drop_seen | output | N_CH | Sticky per-channel FIFO overflow flags |

## Verification
The assertions assume that `rx_div` and `tx_div` stay constant while any byte is in flight, and that they are large enough for a half-bit count to be non-zero. The bench changes `tx_div` only when the transmitter is idle and uses divisors of 16 and 4, or 200 for the slow-drain case. The receive lines are driven on the falling clock edge, aligned to whole bit periods. The only deliberate distortions are the short glitch, the aborted start and the shortened low stop bit. The overflow case slows the transmitter on purpose, so that the FIFO fills and the drop flag can be observed.

// File: rtl/serial_merge_pkg.sv
package serial_merge_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_t;

  // cycles spent in one phase; a receiver confirms the start bit at half a period
  function automatic logic [31:0] phase_len(phase_t ph, logic [31:0] div, logic half_start);
    return (ph == PH_START && half_start) ? (div >> 1) : div;
  endfunction

  // a channel is eligible once it holds a whole frame
  function automatic logic frame_ready(logic [31:0] level, int unsigned frame);
    return level >= frame;
  endfunction

endpackage

// File: rtl/serial_merge_filt.sv
module serial_merge_filt #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  logic [LEN-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '1;
      clean <= 1'b1;
    end else begin
      sr <= {sr[LEN-2:0], raw};
      if (&sr)       clean <= 1'b1;
      else if (~|sr) clean <= 1'b0;
    end
  end

  // R9: the output moves only after every stored sample agreed on the new level
  assert_filter_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> ($past(sr) == {LEN{clean}}));
endmodule

// File: rtl/serial_merge_rx.sv
module serial_merge_rx
  import serial_merge_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic [DIV_W-1:0] div,
  output logic             push,
  output logic             bad_stop,
  output logic [7:0]       data
);
  phase_t           ph;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       nbit;
  logic [7:0]       sh;
  logic             tick;

  assign tick     = (32'(cnt) + 32'd1) == phase_len(ph, 32'(div), 1'b1);
  assign push     = (ph == PH_STOP) && tick && line;
  assign bad_stop = (ph == PH_STOP) && tick && !line;
  assign data     = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          cnt <= '0;
          if (!line) ph <= PH_START;
        end
        PH_START: begin
          if (tick) begin
            cnt  <= '0;
            nbit <= '0;
            ph   <= line ? PH_IDLE : PH_DATA;
          end else cnt <= cnt + 1'b1;
        end
        PH_DATA: begin
          if (tick) begin
            cnt <= '0;
            sh  <= {sh[6:0], line};
            if (nbit == 3'd7) ph <= PH_STOP;
            else nbit <= nbit + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (tick) begin
            cnt <= '0;
            ph  <= PH_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_merge_fifo.sv
module serial_merge_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] level,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          accept, take;

  assign accept = push && (32'(level) < DEPTH);
  assign drop   = push && !accept;
  assign take   = pop && (level != '0);
  assign dout   = mem[rptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      if (take)   rptr <= rptr + 1'b1;
      level <= level + CW'(accept) - CW'(take);
    end
  end

  // R6: the forwarder only pops bytes that are present
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0));
  // R10: the fill level never exceeds the storage
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
endmodule

// File: rtl/serial_merge_tx.sv
module serial_merge_tx
  import serial_merge_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             avail,
  input  logic [7:0]       din,
  output logic             take,
  output logic             line
);
  phase_t           ph;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       nbit;
  logic [7:0]       sh;
  logic             tick;

  assign tick = (32'(cnt) + 32'd1) == phase_len(ph, 32'(div), 1'b0);
  assign take = (ph == PH_IDLE) && avail;
  assign line = (ph == PH_START) ? 1'b0 : (ph == PH_DATA) ? sh[7] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          cnt <= '0;
          if (take) begin
            sh <= din;
            ph <= PH_START;
          end
        end
        PH_START: begin
          if (tick) begin
            cnt  <= '0;
            nbit <= '0;
            ph   <= PH_DATA;
          end else cnt <= cnt + 1'b1;
        end
        PH_DATA: begin
          if (tick) begin
            cnt <= '0;
            sh  <= {sh[6:0], 1'b0};
            if (nbit == 3'd7) ph <= PH_STOP;
            else nbit <= nbit + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (tick) begin
            cnt <= '0;
            ph  <= PH_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R2: a byte taken from a FIFO begins with a low start bit on the next cycle
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !line);
endmodule

// File: rtl/serial_merge_sched.sv
module serial_merge_sched
  import serial_merge_pkg::*;
#(
  parameter int N     = 4,
  parameter int FRAME = 4,
  parameter int CW    = 4,
  localparam int SW   = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][CW-1:0] levels,
  input  logic                take,
  output logic [SW-1:0]       sel,
  output logic                avail
);
  logic [N-1:0]  ready;
  logic [SW-1:0] pick;
  logic [CW-1:0] left;
  logic          busy, grant;

  always_comb begin
    for (int c = 0; c < N; c++) ready[c] = frame_ready(32'(levels[c]), FRAME);
  end

  always_comb begin
    pick = '0;
    for (int c = N - 1; c >= 0; c--) if (ready[c]) pick = SW'(c);
  end

  assign grant = !busy && (|ready);
  assign avail = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sel  <= '0;
      left <= '0;
    end else if (grant) begin
      busy <= 1'b1;
      sel  <= pick;
      left <= CW'(FRAME);
    end else if (busy && take) begin
      left <= left - 1'b1;
      if (left == CW'(1)) busy <= 1'b0;
    end
  end

  // R3: the claimed channel always still holds the rest of its frame
  assert_frame_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(levels[sel]) >= 32'(left)));
  // R5: channel 0 wins whenever it is ready at a grant
  assert_low_index_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && ready[0]) |=> (sel == '0));
endmodule

// File: rtl/serial_merge.sv
module serial_merge #(
  parameter int N_CH     = 4,
  parameter int DIV_W    = 16,
  parameter int DEPTH    = 8,
  parameter int FRAME    = 4,
  parameter int FILT_LEN = 4,
  localparam int CW      = $clog2(DEPTH) + 1,
  localparam int SW      = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  rx_line,
  input  logic [DIV_W-1:0] rx_div,
  input  logic [DIV_W-1:0] tx_div,
  output logic             tx_line,
  output logic [N_CH-1:0]  drop_seen
);
  logic [N_CH-1:0]          clean, push, bad_stop, pop, drop;
  logic [7:0]               rx_byte  [N_CH];
  logic [7:0]               fifo_out [N_CH];
  logic [N_CH-1:0][CW-1:0]  levels;
  logic [SW-1:0]            sel;
  logic                     avail, take;
  logic [N_CH-1:0]          drop_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    serial_merge_filt #(.LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(rx_line[c]), .clean(clean[c]));
    serial_merge_rx #(.DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .line(clean[c]), .div(rx_div),
      .push(push[c]), .bad_stop(bad_stop[c]), .data(rx_byte[c]));
    serial_merge_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push[c]), .din(rx_byte[c]),
      .pop(pop[c]), .dout(fifo_out[c]), .level(levels[c]), .drop(drop[c]));
    assign pop[c] = take && (sel == SW'(c));
  end

  serial_merge_sched #(.N(N_CH), .FRAME(FRAME), .CW(CW)) u_sched (
    .clk(clk), .rst_n(rst_n), .levels(levels), .take(take),
    .sel(sel), .avail(avail));

  serial_merge_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(tx_div), .avail(avail),
    .din(fifo_out[sel]), .take(take), .line(tx_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= '0;
    else        drop_q <= drop_q | drop;
  end
  assign drop_seen = drop_q;

  // R10: once raised, an overflow flag never clears outside reset
  assert_drop_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drop_q) & ~drop_q) == '0);
  // R7: a byte with a low stop bit is never written
  assert_bad_stop_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_stop & push) == '0);
endmodule

// File: tb/serial_merge_test.sv
module serial_merge_test;
  localparam int N  = 4;
  localparam int RX = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] rx_drv = '1;
  logic [15:0] rx_div = 16'(RX);
  logic [15:0] tx_div = 16'd4;
  logic        tx_line;
  logic [N-1:0] drop_seen;

  int total = 0, bad = 0;
  logic [7:0] out_b [64];
  int out_n = 0;

  always #2.5 clk = ~clk;

  serial_merge uut (.clk(clk), .rst_n(rst_n), .rx_line(rx_drv), .rx_div(rx_div),
                    .tx_div(tx_div), .tx_line(tx_line), .drop_seen(drop_seen));

  // stimulus table: channel, four bytes sent (first in top byte), expected output frame
  localparam logic [65:0] VEC [6] = '{
    {2'd0, 32'hA5C3_0F81, 32'hA5C3_0F81},
    {2'd1, 32'h0000_0000, 32'h0000_0000},
    {2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'd3, 32'h0180_7E55, 32'h0180_7E55},
    {2'd1, 32'h1234_5678, 32'h1234_5678},
    {2'd0, 32'hFE01_AA10, 32'hFE01_AA10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input int ch, input logic [7:0] b, input bit good);
    rx_drv[ch] = 1'b0;
    repeat (RX) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      rx_drv[ch] = b[i];
      repeat (RX) @(negedge clk);
    end
    if (good) begin
      rx_drv[ch] = 1'b1;
      repeat (RX) @(negedge clk);
    end else begin
      rx_drv[ch] = 1'b0;
      repeat (RX * 3 / 4) @(negedge clk);
      rx_drv[ch] = 1'b1;
      repeat (RX) @(negedge clk);
    end
  endtask

  task automatic send_frame(input int ch, input logic [31:0] f);
    for (int k = 3; k >= 0; k--) send_byte(ch, f[8*k +: 8], 1'b1);
  endtask

  task automatic wait_out(input int n, input int lim);
    int k = 0;
    while (out_n < n && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic chk_frame(input string req, input int base, input logic [31:0] f);
    for (int k = 0; k < 4; k++) chk(req, 32'(out_b[base + k]), 32'(f[8*(3-k) +: 8]));
  endtask

  // receiver model for the transmit line, independent of the design
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && tx_line == 1'b0) begin
        repeat (int'(tx_div) / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (int'(tx_div)) @(negedge clk);
          b = {b[6:0], tx_line};
        end
        repeat (int'(tx_div)) @(negedge clk);
        if (out_n < 64) out_b[out_n] = b;
        out_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] fa, fb, fc, fd;
    repeat (3) @(negedge clk);
    chk("R1 tx high in reset", 32'(tx_line), 32'd1);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    chk("R1 tx idle", 32'(tx_line), 32'd1);
    chk("R1 no drop flag", 32'(drop_seen), 32'd0);
    chk("R1 nothing sent", 32'(out_n), 32'd0);

    // table of single frames: R2 R3 R11
    foreach (VEC[i]) begin
      out_n = 0;
      send_frame(int'(VEC[i][65:64]), VEC[i][63:32]);
      wait_out(4, 2000);
      chk_frame("R2 R3 R11 table frame", 0, VEC[i][31:0]);
      repeat (100) @(negedge clk);
    end

    // R3 partial frame waits
    out_n = 0;
    send_byte(3, 8'h11, 1'b1);
    send_byte(3, 8'h22, 1'b1);
    send_byte(3, 8'h33, 1'b1);
    repeat (600) @(negedge clk);
    chk("R3 three bytes held", 32'(out_n), 32'd0);
    send_byte(3, 8'h44, 1'b1);
    wait_out(4, 2000);
    chk_frame("R3 completed frame", 0, 32'h1122_3344);

    // R6 two frames back to back on one channel
    out_n = 0;
    send_frame(0, 32'hDEAD_BEEF);
    send_frame(0, 32'h0BAD_F00D);
    wait_out(8, 3000);
    chk_frame("R6 first frame", 0, 32'hDEAD_BEEF);
    chk_frame("R6 second frame", 4, 32'h0BAD_F00D);

    // R4 R5 all channels ready together
    out_n = 0;
    fa = 32'h0A0B_0C0D; fb = 32'h1A1B_1C1D; fc = 32'h2A2B_2C2D; fd = 32'h3A3B_3C3D;
    fork
      send_frame(3, fd);
      send_frame(2, fc);
      send_frame(1, fb);
      send_frame(0, fa);
    join
    wait_out(16, 4000);
    chk_frame("R5 R4 channel 0 first", 0, fa);
    chk_frame("R5 R4 channel 1", 4, fb);
    chk_frame("R5 R4 channel 2", 8, fc);
    chk_frame("R5 R4 channel 3", 12, fd);

    // R9 short glitch ignored
    out_n = 0;
    rx_drv[1] = 1'b0;
    repeat (2) @(negedge clk);
    rx_drv[1] = 1'b1;
    repeat (300) @(negedge clk);
    send_frame(1, 32'h5A69_96A5);
    wait_out(4, 2000);
    repeat (300) @(negedge clk);
    chk("R9 glitch count", 32'(out_n), 32'd4);
    chk_frame("R9 glitch frame", 0, 32'h5A69_96A5);

    // R8 low pulse past the filter but gone at the start-bit check
    out_n = 0;
    rx_drv[2] = 1'b0;
    repeat (6) @(negedge clk);
    rx_drv[2] = 1'b1;
    repeat (300) @(negedge clk);
    send_frame(2, 32'hC001_D00D);
    wait_out(4, 2000);
    repeat (300) @(negedge clk);
    chk("R8 false start count", 32'(out_n), 32'd4);
    chk_frame("R8 false start frame", 0, 32'hC001_D00D);

    // R7 low stop bit discards the byte
    out_n = 0;
    send_byte(0, 8'h3C, 1'b0);
    repeat (100) @(negedge clk);
    send_frame(0, 32'h7788_99AA);
    wait_out(4, 2000);
    repeat (300) @(negedge clk);
    chk("R7 bad stop count", 32'(out_n), 32'd4);
    chk_frame("R7 bad stop frame", 0, 32'h7788_99AA);

    // R10 overflow with a slow transmitter
    tx_div = 16'd200;
    for (int k = 0; k < 12; k++) send_byte(2, 8'(8'h40 + k), 1'b1);
    repeat (20) @(negedge clk);
    chk("R10 drop flag channel 2", 32'(drop_seen), 32'h4);
    repeat (500) @(negedge clk);
    chk("R10 drop flag stays", 32'(drop_seen), 32'h4);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 R10 flag cleared by reset", 32'(drop_seen), 32'd0);
    chk("R1 tx high after reset", 32'(tx_line), 32'd1);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule